// File: doc/BRIEF.md
# Program ROM Bank Window Translator

This block sits between a CPU's upper 32 KB address space (0x8000–0xFFFF) and a program ROM split into 8 KB banks. It turns each CPU address into a flat ROM byte address through four 8 KB windows. Two windows follow software-written bank registers, one follows the second-to-last bank and one is fixed to the final bank. A single mode bit chooses which of the two lower windows holds the switchable bank and which holds the fixed second-to-last bank.

Software programs the translator through an 8-bit CPU write port that shares the CPU address bus. The translation is purely combinational from the current address and the register state, so the ROM address is valid in the same cycle as the CPU address. Register writes take effect at the next clock edge. The bank count is a power-of-two parameter, and every bank number wraps modulo that count.

Top module: `prg_bank_window`

## Requirements
- R1: CPU address bits 15:13 pick the window (0x8000, 0xA000, 0xC000, 0xE000). ROM address bits 12:0 always equal CPU address bits 12:0 inside 0x8000–0xFFFF.
- R2: With the mode bit at 0, window 0x8000 maps to bank register A and window 0xC000 maps to bank BANK_COUNT−2.
- R3: With the mode bit at 1, window 0x8000 maps to bank BANK_COUNT−2 and window 0xC000 maps to bank register A.
- R4: Window 0xA000 always maps to bank register B. Window 0xE000 always maps to bank BANK_COUNT−1.
- R5: A write to any of 0x8000–0x8003 loads bank register A from data bits 4:0 at the next rising clock edge.
- R6: A write to any of 0xA000–0xA003 loads bank register B from data bits 4:0 at the next rising clock edge.
- R7: A write to 0x9002 or 0x9003 loads the mode bit from data bit 1.
- R8: Writes to any other address leave bank A, bank B and the mode bit unchanged. Examples are 0x8004, 0x9000, 0x9001, 0xA004 and addresses below 0x8000. Data bits other than those named in R5–R7 are also ignored.
- R9: The ROM address is (bank mod BANK_COUNT) × 0x2000 + offset. A 5-bit register value such as 0x13 selects bank 3 when BANK_COUNT is 16.
- R10: Asserting rst_n low clears bank A, bank B and the mode bit at once. After rst_n rises, writes are accepted from the third rising clock edge onward.
- R11: For CPU addresses below 0x8000 the ROM address output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | 16 | CPU address, used for translation and for write decode |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| cpu_wdata | input | 8 | Write data |
| rom_addr | output | $clog2(BANK_COUNT)+13 | Translated ROM byte address |

## Verification
Assertions check the following on every clock edge:
- the offset pass-through;
- the zero output below 0x8000;
- the fixed last window;
- the load of each register after a decoded write;
- the stability of all registers when a write misses the decoded addresses.

The bench alone shows the full bank selection of each window under both modes. It also covers:
- the modulo wrap of register values above the bank count;
- the asynchronous clear in the middle of a run;
- the ignored data bits.

These are covered by random write/read mixes checked against an independent model, plus directed corner cases.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;

  localparam int unsigned OFFS_W   = 13;   // 8 KB window
  localparam int unsigned REG_W    = 5;    // bank register width
  localparam int unsigned CPU_AW   = 16;
  localparam int unsigned CPU_DW   = 8;

  typedef enum logic [1:0] {
    WIN_8000 = 2'd0,
    WIN_A000 = 2'd1,
    WIN_C000 = 2'd2,
    WIN_E000 = 2'd3
  } win_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_BANKA = 2'd1,
    TGT_BANKB = 2'd2,
    TGT_MODE  = 2'd3
  } wr_tgt_e;

  typedef struct packed {
    logic [REG_W-1:0] bank_a;
    logic [REG_W-1:0] bank_b;
    logic             swap;
  } bank_state_t;

endpackage

// File: rtl/prg_rst_sync.sv
module prg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_n_sync,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [CPU_DW-1:0] cpu_wdata,
  output bank_state_t       state
);

  localparam logic [CPU_AW-3:0] ADDR_BANKA = 14'h2000; // 0x8000..0x8003
  localparam logic [CPU_AW-3:0] ADDR_BANKB = 14'h2800; // 0xA000..0xA003
  localparam logic [CPU_AW-2:0] ADDR_MODE  = 15'h4801; // 0x9002..0x9003

  wr_tgt_e     tgt;
  logic        wr_ok;
  bank_state_t state_d;
  bank_state_t state_q;

  always_comb begin
    if (cpu_addr[CPU_AW-1:2] == ADDR_BANKA)      tgt = TGT_BANKA;
    else if (cpu_addr[CPU_AW-1:2] == ADDR_BANKB) tgt = TGT_BANKB;
    else if (cpu_addr[CPU_AW-1:1] == ADDR_MODE)  tgt = TGT_MODE;
    else                                         tgt = TGT_NONE;
  end

  assign wr_ok = cpu_wr && rst_n_sync;

  always_comb begin
    state_d = state_q;
    if (wr_ok) begin
      unique case (tgt)
        TGT_BANKA: state_d.bank_a = cpu_wdata[REG_W-1:0];
        TGT_BANKB: state_d.bank_b = cpu_wdata[REG_W-1:0];
        TGT_MODE:  state_d.swap   = cpu_wdata[1];
        default:   state_d        = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R5
  bank_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cpu_wr && cpu_addr[15:2] == 14'h2000) |=> state_q.bank_a == $past(cpu_wdata[4:0]));
  // R6
  bank_b_load_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cpu_wr && cpu_addr[15:2] == 14'h2800) |=> state_q.bank_b == $past(cpu_wdata[4:0]));
  // R7
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cpu_wr && (cpu_addr == 16'h9002 || cpu_addr == 16'h9003)) |=> state_q.swap == $past(cpu_wdata[1]));
  // R8
  miss_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!cpu_wr || (cpu_addr[15:2] != 14'h2000 && cpu_addr[15:2] != 14'h2800 &&
                 cpu_addr != 16'h9002 && cpu_addr != 16'h9003)) |=> $stable(state_q));

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
  import prg_bank_pkg::*;
#(
  parameter int unsigned BANK_COUNT = 16,
  localparam int unsigned BIDX_W    = $clog2(BANK_COUNT),
  localparam int unsigned ROM_W     = BIDX_W + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n_sync,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  bank_state_t       state,
  output logic [ROM_W-1:0]  rom_addr
);

  localparam logic [BIDX_W-1:0] BANK_LAST = BIDX_W'(BANK_COUNT - 1);
  localparam logic [BIDX_W-1:0] BANK_PEN  = BIDX_W'(BANK_COUNT - 2);

  logic [BIDX_W-1:0] idx_a;
  logic [BIDX_W-1:0] idx_b;
  logic [BIDX_W-1:0] bank_sel;
  win_e              win;

  // Wrap register values onto the available bank count
  generate
    if (BIDX_W <= REG_W) begin : g_trunc
      assign idx_a = state.bank_a[BIDX_W-1:0];
      assign idx_b = state.bank_b[BIDX_W-1:0];
    end else begin : g_ext
      assign idx_a = BIDX_W'(state.bank_a);
      assign idx_b = BIDX_W'(state.bank_b);
    end
  endgenerate

  assign win = win_e'(cpu_addr[14:13]);

  always_comb begin
    unique case (win)
      WIN_8000: bank_sel = state.swap ? BANK_PEN : idx_a;
      WIN_A000: bank_sel = idx_b;
      WIN_C000: bank_sel = state.swap ? idx_a : BANK_PEN;
      default:  bank_sel = BANK_LAST;
    endcase
  end

  always_comb begin
    if (cpu_addr[15]) rom_addr = {bank_sel, cpu_addr[OFFS_W-1:0]};
    else              rom_addr = '0;
  end

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    cpu_addr[15] |-> rom_addr[12:0] == cpu_addr[12:0]);
  // R4
  last_window_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (cpu_addr[15:13] == 3'b111) |-> rom_addr[ROM_W-1:OFFS_W] == BANK_LAST);
  // R11
  low_region_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !cpu_addr[15] |-> rom_addr == '0);

endmodule

// File: rtl/prg_bank_window.sv
module prg_bank_window
  import prg_bank_pkg::*;
#(
  parameter int unsigned BANK_COUNT = 16,
  localparam int unsigned ROM_W     = $clog2(BANK_COUNT) + OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_wr,
  input  logic [7:0]        cpu_wdata,
  output logic [ROM_W-1:0]  rom_addr
);

  logic        rst_n_sync;
  bank_state_t state;

  prg_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  prg_bank_regs i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync),
    .cpu_addr   (cpu_addr),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .state      (state)
  );

  prg_window_map #(.BANK_COUNT(BANK_COUNT)) i_map (
    .clk        (clk),
    .rst_n_sync (rst_n_sync),
    .cpu_addr   (cpu_addr),
    .state      (state),
    .rom_addr   (rom_addr)
  );

endmodule

// File: tb/test_prg_bank_window.sv
module test_prg_bank_window;

  localparam int unsigned N     = 16;
  localparam int unsigned ROM_W = $clog2(N) + 13;

  logic             clk;
  logic             rst_n;
  logic [15:0]      cpu_addr;
  logic             cpu_wr;
  logic [7:0]       cpu_wdata;
  logic [ROM_W-1:0] rom_addr;

  int checks;
  int errors;
  int m_a, m_b;
  logic m_swap;

  prg_bank_window #(.BANK_COUNT(N)) i_prg_bank_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .rom_addr  (rom_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [ROM_W-1:0] exp_addr(input logic [15:0] a);
    int unsigned b;
    if (!a[15]) return '0;
    case (a[14:13])
      2'd0:    b = m_swap ? N - 2 : m_a;
      2'd1:    b = m_b;
      2'd2:    b = m_swap ? m_a : N - 2;
      default: b = N - 1;
    endcase
    b = b % N;
    return ROM_W'(b * 8192 + a[12:0]);
  endfunction

  task automatic check_rd(input logic [15:0] a, input string req);
    logic [ROM_W-1:0] e;
    @(negedge clk);
    cpu_addr = a;
    cpu_wr   = 1'b0;
    #2;
    e = exp_addr(a);
    checks++;
    if (rom_addr !== e) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rom_addr, e);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr  = a;
    cpu_wdata = d;
    cpu_wr    = 1'b1;
    if (a[15:2] == 14'h2000)                 m_a = int'(d[4:0]);
    else if (a[15:2] == 14'h2800)            m_b = int'(d[4:0]);
    else if (a == 16'h9002 || a == 16'h9003) m_swap = d[1];
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_a = 0; m_b = 0; m_swap = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic string win_req(input logic [15:0] a);
    if (!a[15]) return "R11";
    case (a[14:13])
      2'd0, 2'd2: return m_swap ? "R3" : "R2";
      default:    return "R4";
    endcase
  endfunction

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] a;
    checks = 0; errors = 0;
    cpu_addr = 16'h0000; cpu_wr = 1'b0; cpu_wdata = 8'h00;
    void'($urandom(32'd20240611));
    do_reset();

    // R10 reset state
    check_rd(16'h8123, "R10");
    check_rd(16'hC456, "R10");
    check_rd(16'hA000, "R10");
    check_rd(16'hFFFF, "R4");
    check_rd(16'h7FFF, "R11");
    check_rd(16'h0000, "R11");

    // R5 R6 R2
    wr(16'h8002, 8'h05);
    wr(16'hA003, 8'h09);
    check_rd(16'h8001, "R5");
    check_rd(16'hBFFF, "R6");
    check_rd(16'hDABC, "R2");
    check_rd(16'h9FFF, "R1");

    // R7 R3
    wr(16'h9003, 8'h02);
    check_rd(16'h8000, "R3");
    check_rd(16'hC7FF, "R3");
    wr(16'h9002, 8'hFD);
    check_rd(16'h8000, "R7");
    check_rd(16'hC000, "R7");

    // R8 ignored writes
    wr(16'h8004, 8'h1F);
    wr(16'h9000, 8'h02);
    wr(16'h9001, 8'h02);
    wr(16'hA004, 8'h1F);
    wr(16'h0000, 8'h1F);
    check_rd(16'h8010, "R8");
    check_rd(16'hA010, "R8");
    check_rd(16'hC010, "R8");

    // R9 wrap and ignored upper data bits
    wr(16'h8000, 8'hF3);
    wr(16'hA001, 8'h1E);
    check_rd(16'h8555, "R9");
    check_rd(16'hA555, "R9");

    // R10 mid-run reset
    wr(16'h9003, 8'h02);
    do_reset();
    check_rd(16'h8000, "R10");
    check_rd(16'hC000, "R10");
    check_rd(16'hA000, "R10");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned op;
      op = $urandom_range(0, 5);
      case (op)
        0: wr(16'h8000 | 16'($urandom_range(0, 7)), 8'($urandom));
        1: wr(16'hA000 | 16'($urandom_range(0, 7)), 8'($urandom));
        2: wr(16'h9000 | 16'($urandom_range(0, 7)), 8'($urandom));
        3: wr(16'($urandom), 8'($urandom));
        default: begin
          a = 16'($urandom);
          check_rd(a, win_req(a));
        end
      endcase
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule